// File: doc/BRIEF.md
# Daisy-Chained Sensor Bus Sequencer

This block decides when one device in a chain of identical sensor devices may drive a shared pair of bus lines (line A and line C). All devices share one clock. Each device samples an active-low chain enable on the rising clock edge. Once it sees the enable low, it takes its turn on the bus. At the falling edge that ends its turn, it releases the lines and pulls its own active-low enable output low, which starts the next device. Analog levels are carried as W-bit words. The three-state drivers are modelled as one output-enable per line, and each data output reads zero whenever its line is not driven.

Three transfer modes exist:

- The sine/reference mode and the differential mode each take two clock pulses and send two pairs of values.
- The quadrature mode takes one pulse and passes two A/B bits onto bit 0 of the lines.

The block does not generate the waveforms. It only selects and gates the values it is given. A phase output shows which pulse of the turn is on the bus, so that several chained instances can be watched together.

Top module: `chain_bus_seq`

## Requirements
- R1: The chain enable `en_in_n` is sampled only at rising clock edges. If it goes low just after a rising edge, or at a falling edge, no turn starts before the next rising edge.
- R2: Mode code 00 (and the reserved code 11, which behaves the same) lasts two pulses. In the first pulse, line A carries `sin_in` and line C carries `cos_in`. From the next rising edge, line A carries `vref_in` and line C carries `gain_in`.
- R3: Mode code 01 lasts two pulses. In the first pulse, the lines carry `sin_in` and `cos_in`. From the second rising edge, they carry `sin_inv` and `cos_inv`.
- R4: Mode code 10 lasts one pulse. If both quadrature inputs are 0 at the rising edge that starts the turn, bit 0 of line A follows `quad_a` and bit 0 of line C follows `quad_b`, with all other bits 0. Otherwise both lines are held at 0 for the whole turn.
- R5: In mode code 10, both lines read 0 while `err` is high, even while they are driven.
- R6: The turn ends at the falling edge of its last pulse: the second pulse in modes 00, 01 and 11, and the first pulse in mode 10. At that edge, `oe_a` and `oe_c` drop and `en_out_n` goes low. While `en_in_n` stays low afterwards, `en_out_n` stays low and the device does not drive again.
- R7: When the lines are not driven, `oe_a` and `oe_c` are 0 and `line_a` and `line_c` are 0. Changes on the data inputs have no effect on them.
- R8: Whenever `en_in_n` is high, the lines are released at once and `en_out_n` is high, so raising the enable of the first device clears the whole chain. A new turn needs a fresh low sample at a rising edge.
- R9: The mode is captured at the rising edge that starts a turn. Later changes to `mode` do not affect that turn.
- R10: While `rst` is high at a rising edge, the block returns to idle: the lines are undriven, `phase` is 0 and `en_out_n` is high.
- R11: `phase` reads 1 during the first pulse and 2 during the second pulse while the lines are driven, and 0 otherwise. In a chain of instances, at most one instance drives at any time, and each instance drives in chain order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared chain clock |
| rst | input | 1 | Synchronous reset, active high |
| en_in_n | input | 1 | Chain enable from the previous device, active low |
| mode | input | 2 | Transfer mode: 00 sine/reference, 01 differential, 10 quadrature, 11 same as 00 |
| err | input | 1 | Error flag; forces both lines low in quadrature mode |
| sin_in | input | W | Non-inverted sine level |
| cos_in | input | W | Non-inverted cosine level |
| sin_inv | input | W | Inverted sine level |
| cos_inv | input | W | Inverted cosine level |
| vref_in | input | W | Reference level |
| gain_in | input | W | Gain indicator level |
| quad_a | input | 1 | Quadrature A bit |
| quad_b | input | 1 | Quadrature B bit |
| line_a | output | W | Value on bus line A (0 when undriven) |
| line_c | output | W | Value on bus line C (0 when undriven) |
| oe_a | output | 1 | Drive enable for line A |
| oe_c | output | 1 | Drive enable for line C |
| en_out_n | output | 1 | Delayed enable to the next device, active low |
| phase | output | 2 | Pulse of the turn now on the bus: 0 idle, 1 first, 2 second |

## Verification
The assertions assume four things about the inputs:

- `en_in_n` changes only between clock edges and never on an edge.
- `rst` is held high across at least one falling edge, so the end-of-turn flag is cleared.
- Chained instances receive the same clock, with each instance's `en_in_n` taken directly from its predecessor's `en_out_n`.
- The data inputs are stable around the edges.

The stimulus moves every input half a nanosecond after a clock edge, or after a falling edge in the sampling test. It holds reset for several full cycles, and it builds the chain from three instances wired output to input.

// File: rtl/chain_bus_seq.sv
`timescale 1ns/1ps
module chain_bus_seq #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_in_n,
  input  logic [1:0]   mode,
  input  logic         err,
  input  logic [W-1:0] sin_in,
  input  logic [W-1:0] cos_in,
  input  logic [W-1:0] sin_inv,
  input  logic [W-1:0] cos_inv,
  input  logic [W-1:0] vref_in,
  input  logic [W-1:0] gain_in,
  input  logic         quad_a,
  input  logic         quad_b,
  output logic [W-1:0] line_a,
  output logic [W-1:0] line_c,
  output logic         oe_a,
  output logic         oe_c,
  output logic         en_out_n,
  output logic [1:0]   phase
);
  localparam logic [1:0] M_SREF = 2'd0, M_DIFF = 2'd1, M_QUAD = 2'd2;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_ONE = 2'd1, PH_TWO = 2'd2;

  logic [1:0] ph, mode_q;
  logic       armed, done;
  logic       last_pulse, active, quad_ok;

  assign last_pulse = (ph == PH_TWO) || (ph == PH_ONE && mode_q == M_QUAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      mode_q <= M_SREF;
      armed  <= 1'b0;
    end else if (en_in_n) begin
      ph <= PH_IDLE;
    end else begin
      case (ph)
        PH_IDLE: if (!done) begin
          ph     <= PH_ONE;
          mode_q <= (mode == 2'b11) ? M_SREF : mode;
          armed  <= !quad_a && !quad_b;
        end
        PH_ONE:  ph <= (mode_q == M_QUAD) ? PH_IDLE : PH_TWO;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk) begin
    if (rst || en_in_n) done <= 1'b0;
    else if (last_pulse) done <= 1'b1;
  end

  assign active   = (ph != PH_IDLE) && !done && !en_in_n;
  assign oe_a     = active;
  assign oe_c     = active;
  assign en_out_n = rst | en_in_n | ~done;
  assign phase    = active ? ph : PH_IDLE;
  assign quad_ok  = armed && !err;

  always_comb begin
    line_a = '0;
    line_c = '0;
    if (active) begin
      case (mode_q)
        M_QUAD: begin
          line_a = {{(W-1){1'b0}}, quad_a & quad_ok};
          line_c = {{(W-1){1'b0}}, quad_b & quad_ok};
        end
        M_DIFF: begin
          line_a = (ph == PH_ONE) ? sin_in : sin_inv;
          line_c = (ph == PH_ONE) ? cos_in : cos_inv;
        end
        default: begin
          line_a = (ph == PH_ONE) ? sin_in : vref_in;
          line_c = (ph == PH_ONE) ? cos_in : gain_in;
        end
      endcase
    end
  end
endmodule

module chain_bus_seq_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         en_in_n,
  input logic         oe_a,
  input logic         oe_c,
  input logic         en_out_n,
  input logic [1:0]   phase,
  input logic [W-1:0] line_a,
  input logic [W-1:0] line_c
);
  a_r7_oe_pair: assert property (@(posedge clk) disable iff (rst) oe_a == oe_c);
  a_r7_quiet_lines: assert property (@(posedge clk) disable iff (rst)
    !oe_a |-> (line_a == '0 && line_c == '0));
  a_r6_no_overlap: assert property (@(negedge clk) disable iff (rst) !en_out_n |-> !oe_a);
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    en_in_n |-> (!oe_a && en_out_n));
  a_r11_phase_live: assert property (@(negedge clk) disable iff (rst)
    oe_a |-> (phase == 2'd1 || phase == 2'd2));
  a_r11_phase_order: assert property (@(negedge clk) disable iff (rst)
    phase == 2'd2 |-> $past(phase) == 2'd1);
  a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phase == 2'd0 && en_out_n));
endmodule

bind chain_bus_seq chain_bus_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en_in_n(en_in_n), .oe_a(oe_a), .oe_c(oe_c),
  .en_out_n(en_out_n), .phase(phase), .line_a(line_a), .line_c(line_c)
);

// File: tb/chain_bus_seq_test.sv
`timescale 1ns/1ps
module chain_bus_seq_test;
  localparam int W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, en_n = 1'b1, err = 1'b0, qa = 1'b0, qb = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [W-1:0] s_p = 12'h1A1, c_p = 12'h2B2, s_n = 12'h3C3, c_n = 12'h4D4;
  logic [W-1:0] vr = 12'h5E5, gn = 12'h6F6;
  logic [W-1:0] la, lc;
  logic oa, oc, nxt;
  logic [1:0] ph;

  chain_bus_seq #(.W(W)) uut (
    .clk(clk), .rst(rst), .en_in_n(en_n), .mode(mode), .err(err),
    .sin_in(s_p), .cos_in(c_p), .sin_inv(s_n), .cos_inv(c_n),
    .vref_in(vr), .gain_in(gn), .quad_a(qa), .quad_b(qb),
    .line_a(la), .line_c(lc), .oe_a(oa), .oe_c(oc), .en_out_n(nxt), .phase(ph));

  logic c_en_n = 1'b1;
  logic [3:0] ch_n;
  logic [2:0] ch_oe, ch_oc;
  logic [W-1:0] ch_la [3];
  logic [W-1:0] ch_lc [3];
  logic [1:0] ch_ph [3];
  assign ch_n[0] = c_en_n;
  for (genvar g = 0; g < 3; g++) begin : g_chain
    chain_bus_seq #(.W(W)) dev (
      .clk(clk), .rst(rst), .en_in_n(ch_n[g]), .mode(2'(g)), .err(1'b0),
      .sin_in(s_p), .cos_in(c_p), .sin_inv(s_n), .cos_inv(c_n),
      .vref_in(vr), .gain_in(gn), .quad_a(qa), .quad_b(qb),
      .line_a(ch_la[g]), .line_c(ch_lc[g]), .oe_a(ch_oe[g]), .oe_c(ch_oc[g]),
      .en_out_n(ch_n[g+1]), .phase(ch_ph[g]));
  end

  int checks = 0, errors = 0;
  string req = "R10";
  bit finished = 0;
  bit [2:0] drove = '0;

  int pos = 0, mq = 0;
  bit fin = 0, arm = 0;
  always @(posedge clk) begin
    if (rst || en_n) pos = 0;
    else if (pos == 0) begin
      if (!fin) begin
        pos = 1;
        mq = (mode == 2'd3) ? 0 : int'(mode);
        arm = (qa == 1'b0 && qb == 1'b0);
      end
    end else if (pos == 1 && mq != 2) pos = 2;
    else pos = 0;
  end
  always @(negedge clk) begin
    if (rst || en_n) fin = 0;
    else if (pos == 2 || (pos == 1 && mq == 2)) fin = 1;
  end

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit act_on;
    logic [W-1:0] ea, ec;
    act_on = (pos != 0) && !fin && !en_n;
    ea = '0; ec = '0;
    if (act_on) begin
      if (mq == 2) begin
        ea = W'(qa & arm & ~err);
        ec = W'(qb & arm & ~err);
      end else if (pos == 1) begin
        ea = s_p; ec = c_p;
      end else if (mq == 1) begin
        ea = s_n; ec = c_n;
      end else begin
        ea = vr; ec = gn;
      end
    end
    chk("line_a", la, ea);
    chk("line_c", lc, ec);
    chk("oe", W'({oa, oc}), W'({act_on, act_on}));
    chk("en_out_n", W'(nxt), W'(rst | en_n | !fin));
    chk("phase", W'(ph), act_on ? W'(pos) : '0);
    checks++;
    if ($countones(ch_oe) > 1 || ch_oe != ch_oc) begin
      errors++;
      $display("FAIL R11 chain drivers actual=%b expected=one-hot-or-zero", ch_oe);
    end
    drove |= ch_oe;
  endtask

  always @(posedge clk) begin #1.25; compare(); end
  always @(negedge clk) begin #1.25; compare(); end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(2);

    req = "R2"; mode = 2'd0; en_n = 0; tick(4); en_n = 1; tick(2);
    req = "R3"; mode = 2'd1; en_n = 0; tick(4); en_n = 1; tick(2);
    req = "R2"; mode = 2'd3; en_n = 0; tick(4); en_n = 1; tick(2);

    req = "R4"; mode = 2'd2; qa = 0; qb = 0; en_n = 0; tick(1);
    qa = 1; qb = 0; tick(1); qa = 0; qb = 1; tick(2); en_n = 1; tick(2);
    req = "R4"; qa = 1; qb = 1; en_n = 0; tick(1); qa = 1; qb = 0; tick(3); en_n = 1; tick(2);
    req = "R5"; qa = 0; qb = 0; en_n = 0; tick(1); err = 1; qa = 1; qb = 1; tick(3);
    en_n = 1; err = 0; qa = 0; qb = 0; tick(2);

    req = "R9"; mode = 2'd0; en_n = 0; tick(1); mode = 2'd2; tick(4); en_n = 1; tick(1);
    mode = 2'd1; tick(1);

    req = "R1"; @(negedge clk); #0.5 en_n = 0; tick(1); tick(4); en_n = 1; tick(2);

    req = "R8"; en_n = 0; tick(1); en_n = 1; tick(2); en_n = 0; tick(5); en_n = 1; tick(1);

    req = "R6"; mode = 2'd0; en_n = 0; tick(8); en_n = 1; tick(2);

    req = "R7"; for (int i = 0; i < 6; i++) begin s_p = s_p + 12'h11; vr = vr ^ 12'hFFF; tick(1); end

    req = "R10"; mode = 2'd1; en_n = 0; tick(1); rst = 1; tick(2); rst = 0; tick(4); en_n = 1; tick(2);

    req = "R11"; drove = '0; c_en_n = 0; tick(10);
    checks++;
    if (drove !== 3'b111) begin
      errors++;
      $display("FAIL R11 chain coverage actual=%b expected=111", drove);
    end
    c_en_n = 1; #0.5;
    checks++;
    if (ch_oe !== 3'b000 || ch_n[3:1] !== 3'b111) begin
      errors++;
      $display("FAIL R8 chain clear actual=%b/%b expected=000/111", ch_oe, ch_n[3:1]);
    end
    tick(2);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end
endmodule